// File: doc/BRIEF.md
# Quad Line Interface Control and Reset Block

This block holds the control state for a four-channel line interface. One global control word and four per-channel control words are written and read over a simple synchronous register bus. Each channel word drives a standby (powerdown) output and an alarm-mask output. A sticky alarm status word collects alarm events from the channels. An interrupt output is raised while any status bit of an unmasked channel is set.

Two reset requests are combined: an active-low hardware reset pin and a software reset bit in the global word. Either request starts a hold counter. The internal reset (`core_rst_n`) is applied only when the request has lasted the full hold time. The internal reset clears the status word and the interrupt, and it clears the global word except for the software reset bit. The per-channel words are left unchanged. The software reset bit has no power-on value, so software must write it to zero first.

An in-circuit-test input is decoded into two output-enable groups: one for the line drivers and one for every other output. A mode bit chooses between floating everything and floating only the line drivers. The hardware reset pin forces that mode bit to zero.

Top module: `lic_ctrl`

## Requirements
- R1: A write to address 6+n (n = 0..3) stores the byte in channel word n, and a read at that address returns it. Bit 0 of channel word n drives `pwrdn[n]` and bit 1 drives `amask[n]`.
- R2: The global word at address 4 is readable and writable. Bit 1 is the software reset request and bit 3 is the test mode bit. Reads at an unmapped address return 0.
- R3: A reset request (`hw_rst_n` low, or global bit 1 set) pulls `core_rst_n` low only after it has been present for HOLD_CYC consecutive clock edges. A shorter request has no effect on `core_rst_n` or on the status word.
- R4: `core_rst_n` returns high on the first clock edge at which the request is absent.
- R5: While the internal reset is active, the status word reads 0 and `irq` is low.
- R6: The internal reset leaves all four channel words unchanged.
- R7: The internal reset clears every bit of the global word except bit 1.
- R8: On each clock edge while `hw_rst_n` is low, the test mode bit (global bit 3) is cleared, even if the internal reset is not yet applied.
- R9: With `ict_n` low and the test mode bit at 0, both `drv_oe` and `misc_oe` are low.
- R10: With `ict_n` low and the test mode bit at 1, only `drv_oe` is low and `misc_oe` stays high. With `ict_n` high, both are high.
- R11: A pulse on `alarm_evt[n]` sets status bit n at address 10, and the bit stays set until the internal reset. `irq` is the OR of the status bits whose channel mask bit is 0.
- R12: The status word at address 10 is read-only. A write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| hw_rst_n | input | 1 | Hardware reset request, active low |
| ict_n | input | 1 | In-circuit-test request, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| alarm_evt | input | 4 | Per-channel alarm event pulses |
| pwrdn | output | 4 | Per-channel standby control |
| amask | output | 4 | Per-channel alarm mask |
| irq | output | 1 | Interrupt, high while an unmasked status bit is set |
| core_rst_n | output | 1 | Qualified internal reset, active low |
| drv_oe | output | 1 | Output enable for the line drivers |
| misc_oe | output | 1 | Output enable for all other outputs |

## Verification
The hardest case to reach is a reset request that stops one edge short of the hold time. From the ports it looks exactly like a request that is about to succeed. The bench drives the pin low for fewer edges than HOLD_CYC and then confirms that the status word and `core_rst_n` did not change. It also confirms that the test mode bit was still cleared, because that bit responds to the pin at once. The software path needs its own case, because its request is a register bit: the bench counts the edge spent on the register write before the hold count begins. On release, it confirms that one further edge is needed once the bit is written back to zero.

// File: rtl/lic_pkg.sv
// Package: shared constants of the quad line interface control block.
// Assumes a 4-bit address bus and 8-bit registers.
package lic_pkg;
    localparam int AW        = 4;
    localparam int DW        = 8;
    localparam int ADDR_GLB  = 4;
    localparam int ADDR_CH0  = 6;
    localparam int ADDR_STAT = 10;
    localparam int SW_BIT    = 1;
    localparam int ICT_BIT   = 3;
    localparam int PD_BIT    = 0;
    localparam int MASK_BIT  = 1;
endpackage

// File: rtl/lic_rst_qual.sv
// Module: reset request qualifier.
// Converts a combined reset request into an internal reset. The reset is
// asserted only after the request has been seen for HOLD_CYC clock edges,
// and it is removed on the first edge without the request.
// Assumes that the request is synchronous to clk.
module lic_rst_qual #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic req,
    output logic rst_act
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    // Count consecutive request cycles and raise the reset at the full count.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q   <= '0;
            rst_act <= 1'b0;
        end else if (!req) begin
            cnt_q   <= '0;
            rst_act <= 1'b0;
        end else begin
            if (cnt_q != HOLD_V) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == HOLD_V - 1'b1) rst_act <= 1'b1;
        end
    end

    AST_ACT_AFTER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_act) |-> (cnt_q == HOLD_V) && $past(req)); // R3
    AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!por_n)
        !req |=> !rst_act); // R4
endmodule

// File: rtl/lic_regs.sv
// Module: global and per-channel control registers.
// The global word clears on internal reset except the software reset bit.
// The software reset bit has no power-on value. The hardware pin clears the
// test mode bit on every edge. The channel words ignore the internal reset.
module lic_regs
    import lic_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    hw_rst_n,
    input  logic                    rst_act,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wr_data,
    output logic [DW-1:0]           glb_q,
    output logic [NCH-1:0][DW-1:0]  chan_q
);
    localparam logic [DW-1:0] SW_MASK = DW'(1) << SW_BIT;

    logic          swrst_q;
    logic [DW-1:0] glb_oth_q;
    logic          glb_hit;

    assign glb_hit = wr_en && (addr == AW'(ADDR_GLB));

    // Software reset bit: written only, deliberately without power-on reset.
    always_ff @(posedge clk) begin
        if (glb_hit) swrst_q <= wr_data[SW_BIT];
    end

    // Remaining global bits: cleared by reset, test mode forced low by the pin.
    always_ff @(posedge clk) begin
        if (!por_n || rst_act) begin
            glb_oth_q <= '0;
        end else begin
            if (glb_hit) glb_oth_q <= wr_data & ~SW_MASK;
            if (!hw_rst_n) glb_oth_q[ICT_BIT] <= 1'b0;
        end
    end

    assign glb_q = (glb_oth_q & ~SW_MASK) | ({DW{swrst_q}} & SW_MASK);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // Channel control word: kept across internal reset.
        always_ff @(posedge clk) begin
            if (!por_n) chan_q[ch] <= '0;
            else if (wr_en && addr == AW'(ADDR_CH0 + ch)) chan_q[ch] <= wr_data;
        end
    end

    AST_CHAN_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        rst_act && !wr_en |=> $stable(chan_q)); // R6
    AST_PIN_CLEARS_MODE: assert property (@(posedge clk) disable iff (!por_n)
        !hw_rst_n |=> !glb_q[ICT_BIT]); // R8
    AST_RST_CLEARS_GLB: assert property (@(posedge clk) disable iff (!por_n)
        rst_act |=> ((glb_q & ~SW_MASK) == '0)); // R7
endmodule

// File: rtl/lic_status.sv
// Module: sticky alarm status and interrupt.
// Sets status bits from alarm event pulses and holds them until the
// internal reset. The interrupt ORs the bits of unmasked channels.
module lic_status #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           rst_act,
    input  logic [NCH-1:0] alarm_evt,
    input  logic [NCH-1:0] amask,
    output logic [NCH-1:0] stat_q,
    output logic           irq
);
    // Collect alarm events; internal reset wipes them.
    always_ff @(posedge clk) begin
        if (!por_n || rst_act) stat_q <= '0;
        else                   stat_q <= stat_q | alarm_evt;
    end

    assign irq = |(stat_q & ~amask);

    AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
        rst_act |=> (stat_q == '0) && !irq); // R5
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !rst_act |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R11
endmodule

// File: rtl/lic_oe.sv
// Module: in-circuit-test output-enable decode.
// When ict_n is low, the line drivers are floated. The other outputs are
// floated too when the mode bit is 0.
module lic_oe (
    input  logic ict_n,
    input  logic ict_mode,
    output logic drv_oe,
    output logic misc_oe
);
    // Decode the test request into two enable groups.
    always_comb begin
        drv_oe  = ict_n;
        misc_oe = ict_n || ict_mode;
    end

    // Invariant between the two enable groups.
    always_comb begin
        AST_DRV_FLOATS_FIRST: assert (misc_oe || !drv_oe); // R9
    end
endmodule

// File: rtl/lic_ctrl.sv
// Module: top of the quad line interface control block.
// Combines the reset requests, holds the control registers, the alarm status
// and the test output enables, and returns read data for the current address
// without a register stage.
module lic_ctrl
    import lic_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int HOLD_CYC = 1000
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           hw_rst_n,
    input  logic           ict_n,
    input  logic           wr_en,
    input  logic [3:0]     addr,
    input  logic [7:0]     wr_data,
    output logic [7:0]     rd_data,
    input  logic [NCH-1:0] alarm_evt,
    output logic [NCH-1:0] pwrdn,
    output logic [NCH-1:0] amask,
    output logic           irq,
    output logic           core_rst_n,
    output logic           drv_oe,
    output logic           misc_oe
);
    logic                   rst_act;
    logic                   rst_req;
    logic [DW-1:0]          glb_q;
    logic [NCH-1:0][DW-1:0] chan_q;
    logic [NCH-1:0]         stat_q;

    assign rst_req    = !hw_rst_n || glb_q[SW_BIT];
    assign core_rst_n = !rst_act;

    lic_rst_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
        .clk(clk), .por_n(por_n), .req(rst_req), .rst_act(rst_act)
    );

    lic_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .rst_act(rst_act),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .glb_q(glb_q), .chan_q(chan_q)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ctl
        assign pwrdn[ch] = chan_q[ch][PD_BIT];
        assign amask[ch] = chan_q[ch][MASK_BIT];
    end

    lic_status #(.NCH(NCH)) u_stat (
        .clk(clk), .por_n(por_n), .rst_act(rst_act),
        .alarm_evt(alarm_evt), .amask(amask), .stat_q(stat_q), .irq(irq)
    );

    lic_oe u_oe (
        .ict_n(ict_n), .ict_mode(glb_q[ICT_BIT]),
        .drv_oe(drv_oe), .misc_oe(misc_oe)
    );

    // Read multiplexer over the global, channel and status words.
    always_comb begin
        rd_data = '0;
        if (addr == AW'(ADDR_GLB))  rd_data = glb_q;
        if (addr == AW'(ADDR_STAT)) rd_data = DW'(stat_q);
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(ADDR_CH0 + c)) rd_data = chan_q[c];
        end
    end

    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        wr_en && addr == AW'(ADDR_STAT) && alarm_evt == '0 && !rst_act
        |=> $stable(stat_q)); // R12
endmodule

// File: tb/lic_ctrl_tb_top.sv
module lic_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       hw_rst_n = 1'b1;
    logic       ict_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] alarm_evt = '0;
    logic [7:0] rd_data;
    logic [3:0] pwrdn, amask;
    logic       irq, core_rst_n, drv_oe, misc_oe;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lic_ctrl #(.NCH(4), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .ict_n(ict_n),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .alarm_evt(alarm_evt), .pwrdn(pwrdn), .amask(amask), .irq(irq),
        .core_rst_n(core_rst_n), .drv_oe(drv_oe), .misc_oe(misc_oe)
    );

    // Bus table: {is_write, address, data or expected read}.
    localparam int NV = 13;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'd6,  8'h01}, {1'b1, 4'd7,  8'h02}, {1'b1, 4'd8,  8'h03},
        {1'b1, 4'd9,  8'hF0}, {1'b0, 4'd6,  8'h01}, {1'b0, 4'd7,  8'h02},
        {1'b0, 4'd8,  8'h03}, {1'b0, 4'd9,  8'hF0}, {1'b1, 4'd10, 8'hFF},
        {1'b0, 4'd10, 8'h00}, {1'b1, 4'd4,  8'h08}, {1'b0, 4'd4,  8'h08},
        {1'b0, 4'd3,  8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=timeout exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        wr(4'd4, 8'h00);                      // clear the uninitialized bit first
        @(negedge clk);
        chk("R5 reset irq", {7'd0, irq}, 8'h00);
        chk("R1 reset pwrdn", {4'd0, pwrdn}, 8'h00);
        chk("R10 idle oe", {6'd0, drv_oe, misc_oe}, 8'h03);
        chk("R3 core idle", {7'd0, core_rst_n}, 8'h01);

        // Table walk: R1 R2 R12
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) wr(VEC[i][11:8], VEC[i][7:0]);
            else begin
                rd(VEC[i][11:8], v);
                chk($sformatf("R1/R2/R12 vec%0d", i), v, VEC[i][7:0]);
            end
        end
        chk("R1 pwrdn", {4'd0, pwrdn}, 8'h05);
        chk("R1 amask", {4'd0, amask}, 8'h06);

        // Test output enables, mode bit is 1: R10
        ict_n = 1'b0; #1;
        chk("R10 mode1", {6'd0, drv_oe, misc_oe}, 8'h01);
        wr(4'd4, 8'h00);
        #1;
        chk("R9 mode0", {6'd0, drv_oe, misc_oe}, 8'h00);
        ict_n = 1'b1; #1;
        chk("R10 released", {6'd0, drv_oe, misc_oe}, 8'h03);

        // Status and interrupt: R11
        @(negedge clk); alarm_evt = 4'hF;
        @(negedge clk); alarm_evt = 4'h0;
        @(negedge clk);
        rd(4'd10, v);
        chk("R11 status set", v, 8'h0F);
        chk("R11 irq unmasked", {7'd0, irq}, 8'h01);
        wr(4'd6, 8'h03);
        wr(4'd9, 8'h02);
        #1;
        chk("R11 irq all masked", {7'd0, irq}, 8'h00);
        rd(4'd10, v);
        chk("R11 status sticky", v, 8'h0F);

        // Short hardware pulse: R3 and R8
        wr(4'd4, 8'h08);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk);
        rd(4'd4, v);
        chk("R8 pin clears mode", v, 8'h00);
        repeat (HOLD - 3) @(negedge clk);
        chk("R3 short pulse core", {7'd0, core_rst_n}, 8'h01);
        hw_rst_n = 1'b1;
        @(negedge clk);
        rd(4'd10, v);
        chk("R3 short pulse status", v, 8'h0F);
        chk("R3 short pulse core after", {7'd0, core_rst_n}, 8'h01);

        // Full hardware reset: R3 R5 R6 R4 R9
        hw_rst_n = 1'b0;
        ict_n = 1'b0;
        repeat (HOLD - 1) @(negedge clk);
        chk("R3 one edge short", {7'd0, core_rst_n}, 8'h01);
        chk("R9 pin forces full float", {6'd0, drv_oe, misc_oe}, 8'h00);
        ict_n = 1'b1;
        @(negedge clk);
        chk("R3 core asserted", {7'd0, core_rst_n}, 8'h00);
        @(negedge clk);
        rd(4'd10, v);
        chk("R5 status cleared", v, 8'h00);
        chk("R5 irq low", {7'd0, irq}, 8'h00);
        rd(4'd6, v);
        chk("R6 ch0 kept", v, 8'h03);
        rd(4'd9, v);
        chk("R6 ch3 kept", v, 8'h02);
        hw_rst_n = 1'b1;
        @(negedge clk);
        chk("R4 hw release", {7'd0, core_rst_n}, 8'h01);

        // Software reset: R3 R7 R4
        wr(4'd4, 8'h0F);
        repeat (HOLD - 1) @(negedge clk);
        chk("R3 sw short", {7'd0, core_rst_n}, 8'h01);
        @(negedge clk);
        chk("R3 sw asserted", {7'd0, core_rst_n}, 8'h00);
        @(negedge clk);
        rd(4'd4, v);
        chk("R7 global cleared", v, 8'h02);
        wr(4'd4, 8'h00);
        chk("R4 sw still held", {7'd0, core_rst_n}, 8'h00);
        @(negedge clk);
        chk("R4 sw release", {7'd0, core_rst_n}, 8'h01);
        rd(4'd7, v);
        chk("R6 ch1 after sw", v, 8'h02);

        summary();
        $finish;
    end
endmodule